// File: doc/BRIEF.md
# Per-CPU Interrupt Source Mask Gate

This block sits between the interrupt-raising devices of a multiprocessor node and the interrupt controller of each CPU. Every request arrives as a level and index pair addressed to one CPU. The block sorts the request into a source class, checks that class against the target CPU's mask register, and either drops the request or passes it on as a one-cycle post. The post carries the request's level and index unchanged. The five classes are console, interval clock, inter-processor interrupt, network and disk. Network and disk share one enable bit, because all level-1 requests are gated together.

Each CPU has its own mask. Software reaches the masks through two write selectors. Selector 0 accepts writes only from even-numbered CPUs and selector 1 only from odd-numbered ones. A write updates the requesting CPU's own mask. If the write also enables a class whose pending line is still high for that CPU, the block posts that class again. Posts that fall due together are held and issued one per cycle in a fixed order, so no accepted request is lost.

Top module: `intgate_top`

## Requirements
- R1: After reset every CPU's mask reads as all ones (32 bits set), `regErr` is low and `postValid` is low.
- R2: A level-0 request with index 0 (console) is forwarded only when bit 0 of the target CPU's mask is set. The forwarded post carries level 0, index 0 and the target CPU, and it is presented in the cycle after the request is sampled unless an earlier post takes precedence.
- R3: A level-2 request with index 0 (clock) is gated by mask bit 6. A level-2 request with index 1 (inter-processor) is gated by mask bit 5. Each is forwarded with its own level and index.
- R4: Every level-1 request is gated by mask bit 2, whatever its index. Index 2 is network, index 3 is disk, and any other index is forwarded with that index. If several such other-index requests wait for the same CPU, one post is made and it carries the latest index.
- R5: Requests whose pair matches none of these classes are dropped: level 0 with a nonzero index, level 2 with an index above 1, and any level-3 request.
- R6: With `regWrEn` high, `regWrSel`=0 is accepted only when `regCpu` is even and `regWrSel`=1 only when it is odd. An accepted write replaces the mask of `regCpu`. `regRdData` always shows the mask of `regCpu`, whatever the selector.
- R7: A write whose selector parity differs from `regCpu` leaves every mask unchanged and sets `regErr`. `regErr` stays set until reset.
- R8: An accepted write re-posts, for the written CPU, every class whose bit in the new value is set and whose pending input is high. Network and disk are re-posted separately, each with its own index.
- R9: At most one post is issued per cycle. Waiting posts go out lowest CPU first, and within a CPU in the order console, clock, inter-processor, network, disk, other level-1.
- R10: A request sampled in the same cycle as an accepted write to its CPU is gated by the newly written value. A request is gated only when it arrives: once accepted, it is held until issued even if its mask bit is cleared meanwhile. A new request for a class that is already waiting on the same CPU merges into the waiting post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Interrupt request strobe |
| reqLevel | input | 2 | Request level (0..3) |
| reqIndex | input | IDX_W | Request index within the level |
| reqCpu | input | CPU_W | Target CPU of the request |
| consPend | input | NUM_CPU | Console still pending, per CPU |
| clkPend | input | NUM_CPU | Clock still pending, per CPU |
| ipiPend | input | NUM_CPU | Inter-processor interrupt still pending, per CPU |
| netPend | input | NUM_CPU | Network still pending, per CPU |
| diskPend | input | NUM_CPU | Disk still pending, per CPU |
| regWrEn | input | 1 | Mask write strobe |
| regWrSel | input | 1 | Mask selector used by the write (0 or 1) |
| regCpu | input | CPU_W | Requesting CPU for the read and the write |
| regWrData | input | MASK_W | New mask value |
| regRdData | output | MASK_W | Mask of the requesting CPU |
| regErr | output | 1 | Sticky wrong-parity write flag |
| postValid | output | 1 | Post pulse to the CPU interrupt controller |
| postLevel | output | 2 | Level of the post |
| postIndex | output | IDX_W | Index of the post |
| postCpu | output | CPU_W | CPU that receives the post |

## Verification
Two functions can fall in the same cycle: a newly arriving request and the re-post scan started by a mask write. The bench raises pending lines, then writes a mask to the same CPU in the very cycle a fresh request for a different class arrives. It also times a clearing write to coincide with a request of that class. A behavioural reference model is compared with the design on every clock. It judges the merged stream: which request survives the new mask, and whether console, clock, inter-processor, network and disk then leave one per cycle in the required order with nothing lost or duplicated.

// File: rtl/intgate_pkg.sv
package intgate_pkg;

  localparam int LVL_W   = 2;
  localparam int NUM_SRC = 6;
  localparam int NUM_CLS = 4;

  localparam logic [LVL_W-1:0] LVL_IRQ0 = 2'd0;
  localparam logic [LVL_W-1:0] LVL_IRQ1 = 2'd1;
  localparam logic [LVL_W-1:0] LVL_IRQ2 = 2'd2;

  typedef logic [2:0] srcT;

  // source slots, in issue priority order
  localparam srcT SRC_CONS = 3'd0;
  localparam srcT SRC_CLK  = 3'd1;
  localparam srcT SRC_IPI  = 3'd2;
  localparam srcT SRC_NET  = 3'd3;
  localparam srcT SRC_DISK = 3'd4;
  localparam srcT SRC_AUX  = 3'd5;

  // mask bit positions that enable each class
  localparam int BIT_CONS = 0;
  localparam int BIT_DEV  = 2;
  localparam int BIT_IPI  = 5;
  localparam int BIT_CLK  = 6;

  // compressed class enable vector: [0] console [1] clock [2] ipi [3] level-1 devices
  localparam int CLS_CONS = 0;
  localparam int CLS_CLK  = 1;
  localparam int CLS_IPI  = 2;
  localparam int CLS_DEV  = 3;

  typedef struct packed {
    logic maskWr;
    logic errSet;
    logic postLoad;
    srcT  postSrc;
  } ctlStrobeT;

endpackage

// File: rtl/intgate_arb.sv
module intgate_arb #(
  parameter int WIDTH = 24,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic [WIDTH-1:0] grantVec,
  output logic             grantAny,
  output logic [IW-1:0]    grantIdx
);

  // fixed priority: lowest slot wins
  always_comb begin
    grantVec = '0;
    grantAny = 1'b0;
    grantIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (reqVec[i] && !grantAny) begin
        grantVec[i] = 1'b1;
        grantAny    = 1'b1;
        grantIdx    = IW'(i);
      end
    end
  end

endmodule

// File: rtl/intgate_ctrl.sv
module intgate_ctrl
  import intgate_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int IDX_W    = 4,
  parameter int NET_IDX  = 2,
  parameter int DISK_IDX = 3,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [LVL_W-1:0]         reqLevel,
  input  logic [IDX_W-1:0]         reqIndex,
  input  logic [CPU_W-1:0]         reqCpu,
  input  logic [NUM_CPU-1:0]       consPend,
  input  logic [NUM_CPU-1:0]       clkPend,
  input  logic [NUM_CPU-1:0]       ipiPend,
  input  logic [NUM_CPU-1:0]       netPend,
  input  logic [NUM_CPU-1:0]       diskPend,
  input  logic                     regWrEn,
  input  logic                     regWrSel,
  input  logic [CPU_W-1:0]         regCpu,
  input  logic [NUM_CLS-1:0]       wrClsEn,
  input  logic [NUM_CPU*NUM_CLS-1:0] curClsEn,
  output ctlStrobeT                strobe,
  output logic [CPU_W-1:0]         postCpuSel,
  output logic [IDX_W-1:0]         postAuxIdx
);

  localparam int SLOTS  = NUM_CPU * NUM_SRC;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]   dueQ, setVec, nextDue, grantVec;
  logic               grantAny;
  logic [SLOT_W-1:0]  grantIdx;
  logic [NUM_SRC-1:0] srcHit;
  logic               wrLegal, wrOk;
  logic [IDX_W-1:0]   auxIdxNow [NUM_CPU];

  assign wrLegal = (regWrSel == regCpu[0]);
  assign wrOk    = regWrEn && wrLegal;

  // classify the incoming level/index pair
  always_comb begin
    srcHit = '0;
    if (reqValid) begin
      case (reqLevel)
        LVL_IRQ0: srcHit[int'(SRC_CONS)] = (reqIndex == '0);
        LVL_IRQ1: begin
          if (reqIndex == IDX_W'(NET_IDX))       srcHit[int'(SRC_NET)]  = 1'b1;
          else if (reqIndex == IDX_W'(DISK_IDX)) srcHit[int'(SRC_DISK)] = 1'b1;
          else                                   srcHit[int'(SRC_AUX)]  = 1'b1;
        end
        LVL_IRQ2: begin
          if (reqIndex == '0)               srcHit[int'(SRC_CLK)] = 1'b1;
          else if (reqIndex == IDX_W'(1))   srcHit[int'(SRC_IPI)] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic               wrHere, reqHere, auxNew;
    logic [NUM_CLS-1:0] effEn;
    logic [NUM_SRC-1:0] pendVec;
    logic [IDX_W-1:0]   auxIdxQ;

    assign wrHere  = wrOk && (regCpu == CPU_W'(c));
    assign reqHere = (reqCpu == CPU_W'(c));
    // requests in the write cycle see the value being written
    assign effEn   = wrHere ? wrClsEn : curClsEn[c*NUM_CLS +: NUM_CLS];
    assign pendVec = {1'b0, diskPend[c], netPend[c], ipiPend[c], clkPend[c], consPend[c]};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int CLS = (s < 3) ? s : CLS_DEV;
      assign setVec[c*NUM_SRC + s] = effEn[CLS] &&
             ((reqHere && srcHit[s]) || (wrHere && pendVec[s]));
    end

    assign auxNew = reqHere && srcHit[int'(SRC_AUX)] && effEn[CLS_DEV];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       auxIdxQ <= '0;
      else if (auxNew) auxIdxQ <= reqIndex;
    end

    assign auxIdxNow[c] = auxNew ? reqIndex : auxIdxQ;
  end

  assign nextDue = dueQ | setVec;

  intgate_arb #(.WIDTH(SLOTS)) u_arb (
    .reqVec   (nextDue),
    .grantVec (grantVec),
    .grantAny (grantAny),
    .grantIdx (grantIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dueQ <= '0;
    else       dueQ <= nextDue & ~grantVec;
  end

  always_comb begin
    postCpuSel = CPU_W'(int'(grantIdx) / NUM_SRC);
    postAuxIdx = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (postCpuSel == CPU_W'(c)) postAuxIdx = auxIdxNow[c];
  end

  assign strobe.maskWr   = wrOk;
  assign strobe.errSet   = regWrEn && !wrLegal;
  assign strobe.postLoad = grantAny;
  assign strobe.postSrc  = srcT'(int'(grantIdx) % NUM_SRC);

  // R9: the arbiter never grants two slots at once
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R10: a waiting post that is not granted is still waiting next cycle
  assert_held_not_lost_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(dueQ & ~grantVec)) |=> ((($past(dueQ) & ~$past(grantVec)) & ~dueQ) == '0));

  // R9: a grant is issued whenever anything is due
  assert_work_conserving_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|dueQ) |-> strobe.postLoad);

endmodule

// File: rtl/intgate_dp.sv
module intgate_dp
  import intgate_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int MASK_W   = 32,
  parameter int IDX_W    = 4,
  parameter int NET_IDX  = 2,
  parameter int DISK_IDX = 3,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobeT                  strobe,
  input  logic [CPU_W-1:0]           regCpu,
  input  logic [MASK_W-1:0]          wrData,
  input  logic [CPU_W-1:0]           postCpuSel,
  input  logic [IDX_W-1:0]           postAuxIdx,
  output logic [NUM_CPU*NUM_CLS-1:0] clsEnFlat,
  output logic [MASK_W-1:0]          rdData,
  output logic                       errSticky,
  output logic                       postValid,
  output logic [LVL_W-1:0]           postLevel,
  output logic [IDX_W-1:0]           postIndex,
  output logic [CPU_W-1:0]           postCpu
);

  logic [NUM_CPU-1:0][MASK_W-1:0] maskQ;
  logic [LVL_W-1:0] nxtLevel;
  logic [IDX_W-1:0] nxtIndex;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        maskQ[c] <= '1;
      else if (strobe.maskWr && (regCpu == CPU_W'(c)))
        maskQ[c] <= wrData;
    end

    assign clsEnFlat[c*NUM_CLS + CLS_CONS] = maskQ[c][BIT_CONS];
    assign clsEnFlat[c*NUM_CLS + CLS_CLK]  = maskQ[c][BIT_CLK];
    assign clsEnFlat[c*NUM_CLS + CLS_IPI]  = maskQ[c][BIT_IPI];
    assign clsEnFlat[c*NUM_CLS + CLS_DEV]  = maskQ[c][BIT_DEV];
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (regCpu == CPU_W'(c)) rdData = maskQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errSticky <= 1'b0;
    else if (strobe.errSet) errSticky <= 1'b1;
  end

  // map the granted slot back onto its level/index pair
  always_comb begin
    nxtLevel = LVL_IRQ1;
    nxtIndex = postAuxIdx;
    case (strobe.postSrc)
      SRC_CONS: begin nxtLevel = LVL_IRQ0; nxtIndex = '0;              end
      SRC_CLK:  begin nxtLevel = LVL_IRQ2; nxtIndex = '0;              end
      SRC_IPI:  begin nxtLevel = LVL_IRQ2; nxtIndex = IDX_W'(1);       end
      SRC_NET:  begin nxtLevel = LVL_IRQ1; nxtIndex = IDX_W'(NET_IDX); end
      SRC_DISK: begin nxtLevel = LVL_IRQ1; nxtIndex = IDX_W'(DISK_IDX); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postLevel <= '0;
      postIndex <= '0;
      postCpu   <= '0;
    end else begin
      postValid <= strobe.postLoad;
      if (strobe.postLoad) begin
        postLevel <= nxtLevel;
        postIndex <= nxtIndex;
        postCpu   <= postCpuSel;
      end
    end
  end

  // R7: the error flag never clears while out of reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R7: a wrong-parity write leaves all masks untouched
  assert_bad_write_keeps_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errSet |=> $stable(maskQ));

  // R5: no post is ever made on level 3
  assert_no_level3_R5: assert property (@(posedge clk) disable iff (!rstN)
    postValid |-> (postLevel != 2'd3));

  // R2: level-0 posts always carry index 0
  assert_console_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && (postLevel == LVL_IRQ0)) |-> (postIndex == '0));

endmodule

// File: rtl/intgate_top.sv
module intgate_top
  import intgate_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int MASK_W   = 32,
  parameter int IDX_W    = 4,
  parameter int NET_IDX  = 2,
  parameter int DISK_IDX = 3,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqLevel,
  input  logic [IDX_W-1:0]   reqIndex,
  input  logic [CPU_W-1:0]   reqCpu,
  input  logic [NUM_CPU-1:0] consPend,
  input  logic [NUM_CPU-1:0] clkPend,
  input  logic [NUM_CPU-1:0] ipiPend,
  input  logic [NUM_CPU-1:0] netPend,
  input  logic [NUM_CPU-1:0] diskPend,
  input  logic               regWrEn,
  input  logic               regWrSel,
  input  logic [CPU_W-1:0]   regCpu,
  input  logic [MASK_W-1:0]  regWrData,
  output logic [MASK_W-1:0]  regRdData,
  output logic               regErr,
  output logic               postValid,
  output logic [1:0]         postLevel,
  output logic [IDX_W-1:0]   postIndex,
  output logic [CPU_W-1:0]   postCpu
);

  ctlStrobeT                  strobe;
  logic [CPU_W-1:0]           postCpuSel;
  logic [IDX_W-1:0]           postAuxIdx;
  logic [NUM_CPU*NUM_CLS-1:0] clsEnFlat;
  logic [NUM_CLS-1:0]         wrClsEn;

  assign wrClsEn = {regWrData[BIT_DEV], regWrData[BIT_IPI],
                    regWrData[BIT_CLK], regWrData[BIT_CONS]};

  intgate_ctrl #(
    .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .NET_IDX(NET_IDX), .DISK_IDX(DISK_IDX)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLevel   (reqLevel),
    .reqIndex   (reqIndex),
    .reqCpu     (reqCpu),
    .consPend   (consPend),
    .clkPend    (clkPend),
    .ipiPend    (ipiPend),
    .netPend    (netPend),
    .diskPend   (diskPend),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .regCpu     (regCpu),
    .wrClsEn    (wrClsEn),
    .curClsEn   (clsEnFlat),
    .strobe     (strobe),
    .postCpuSel (postCpuSel),
    .postAuxIdx (postAuxIdx)
  );

  intgate_dp #(
    .NUM_CPU(NUM_CPU), .MASK_W(MASK_W), .IDX_W(IDX_W),
    .NET_IDX(NET_IDX), .DISK_IDX(DISK_IDX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regCpu     (regCpu),
    .wrData     (regWrData),
    .postCpuSel (postCpuSel),
    .postAuxIdx (postAuxIdx),
    .clsEnFlat  (clsEnFlat),
    .rdData     (regRdData),
    .errSticky  (regErr),
    .postValid  (postValid),
    .postLevel  (postLevel),
    .postIndex  (postIndex),
    .postCpu    (postCpu)
  );

endmodule

// File: tb/sim_intgate_top.sv
module sim_intgate_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqLevel = '0;
  logic [3:0]  reqIndex = '0;
  logic [1:0]  reqCpu = '0;
  logic [3:0]  consPend = '0, clkPend = '0, ipiPend = '0, netPend = '0, diskPend = '0;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [1:0]  regCpu = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regErr, postValid;
  logic [1:0]  postLevel;
  logic [3:0]  postIndex;
  logic [1:0]  postCpu;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  intgate_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .reqIndex(reqIndex), .reqCpu(reqCpu), .consPend(consPend),
    .clkPend(clkPend), .ipiPend(ipiPend), .netPend(netPend),
    .diskPend(diskPend), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regCpu(regCpu), .regWrData(regWrData), .regRdData(regRdData),
    .regErr(regErr), .postValid(postValid), .postLevel(postLevel),
    .postIndex(postIndex), .postCpu(postCpu)
  );

  // ---------------- reference model ----------------
  bit [31:0] maskM [4];
  bit        dueM  [4][6];
  int        auxM  [4];
  bit        errM;
  bit        pvM;
  int        plM, piM, pcM;

  function automatic int bitOf(int s);
    case (s)
      0: return 0;
      1: return 6;
      2: return 5;
      default: return 2;
    endcase
  endfunction

  function automatic bit pendOf(int s, int c);
    case (s)
      0: return consPend[c];
      1: return clkPend[c];
      2: return ipiPend[c];
      3: return netPend[c];
      4: return diskPend[c];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        maskM[c] = '1; auxM[c] = 0;
        for (int s = 0; s < 6; s++) dueM[c][s] = 0;
      end
      errM = 0; pvM = 0; plM = 0; piM = 0; pcM = 0;
    end else begin
      bit legal, ok;
      legal = (int'(regWrSel) == int'(regCpu) % 2);
      ok    = regWrEn && legal;
      if (regWrEn && !legal) errM = 1;
      for (int c = 0; c < 4; c++) begin
        bit [31:0] eff;
        int hit;
        eff = (ok && int'(regCpu) == c) ? regWrData : maskM[c];
        if (reqValid && int'(reqCpu) == c) begin
          hit = -1;
          case (reqLevel)
            2'd0: if (reqIndex == 0) hit = 0;
            2'd1: hit = (reqIndex == 2) ? 3 : (reqIndex == 3) ? 4 : 5;
            2'd2: hit = (reqIndex == 0) ? 1 : (reqIndex == 1) ? 2 : -1;
            default: hit = -1;
          endcase
          if (hit >= 0 && eff[bitOf(hit)]) begin
            dueM[c][hit] = 1;
            if (hit == 5) auxM[c] = int'(reqIndex);
          end
        end
        if (ok && int'(regCpu) == c)
          for (int s = 0; s < 5; s++)
            if (eff[bitOf(s)] && pendOf(s, c)) dueM[c][s] = 1;
      end
      pvM = 0;
      for (int c = 0; c < 4; c++)
        for (int s = 0; s < 6; s++)
          if (dueM[c][s] && !pvM) begin
            pvM = 1; pcM = c; dueM[c][s] = 0;
            case (s)
              0: begin plM = 0; piM = 0; end
              1: begin plM = 2; piM = 0; end
              2: begin plM = 2; piM = 1; end
              3: begin plM = 1; piM = 2; end
              4: begin plM = 1; piM = 3; end
              default: begin plM = 1; piM = auxM[c]; end
            endcase
          end
      if (ok) maskM[regCpu] = regWrData;
    end
  end

  // ---------------- comparison ----------------
  task automatic compare();
    vectors++;
    if (postValid !== pvM ||
        (pvM && (int'(postLevel) != plM || int'(postIndex) != piM || int'(postCpu) != pcM))) begin
      miscompares++;
      $display("FAIL %s post: got v=%0b l=%0d i=%0d c=%0d exp v=%0b l=%0d i=%0d c=%0d",
               phase, postValid, postLevel, postIndex, postCpu, pvM, plM, piM, pcM);
    end
    vectors++;
    if (regRdData !== maskM[regCpu]) begin
      miscompares++;
      $display("FAIL %s read cpu%0d: got %h exp %h", phase, regCpu, regRdData, maskM[regCpu]);
    end
    vectors++;
    if (regErr !== errM) begin
      miscompares++;
      $display("FAIL %s err flag: got %0b exp %0b", phase, regErr, errM);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    reqValid = 1'b0;
    regWrEn  = 1'b0;
  endtask

  task automatic req(int c, int l, int i);
    reqValid = 1'b1; reqCpu = 2'(c); reqLevel = 2'(l); reqIndex = 4'(i);
  endtask

  task automatic wr(int c, int sel, logic [31:0] d);
    regWrEn = 1'b1; regCpu = 2'(c); regWrSel = sel[0]; regWrData = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values of every mask, flag and post output
    phase = "R1";
    for (int c = 0; c < 4; c++) begin regCpu = 2'(c); tick(); end

    // R2: console forwarded with full mask, dropped with bit 0 clear
    phase = "R2";
    req(1, 0, 0); tick(); idle(1);
    wr(0, 0, 32'hFFFF_FFFE); tick();
    req(0, 0, 0); tick(); idle(1);
    req(1, 0, 0); tick(); idle(1);

    // R3: clock gated by bit 6, inter-processor by bit 5
    phase = "R3";
    req(2, 2, 0); tick(); req(2, 2, 1); tick(); idle(1);
    wr(2, 0, 32'hFFFF_FFBF); tick();
    req(2, 2, 0); tick(); req(2, 2, 1); tick(); idle(1);
    wr(2, 0, 32'hFFFF_FFDF); tick();
    req(2, 2, 0); tick(); req(2, 2, 1); tick(); idle(1);

    // R4: level-1 network, disk and other indices, gated by bit 2
    phase = "R4";
    req(3, 1, 2); tick(); req(3, 1, 3); tick(); req(3, 1, 9); tick(); idle(1);
    wr(3, 1, 32'hFFFF_FFFB); tick();
    req(3, 1, 2); tick(); req(3, 1, 3); tick(); req(3, 1, 7); tick(); idle(1);

    // R5: unrecognised pairs are dropped
    phase = "R5";
    req(1, 0, 4); tick(); req(1, 2, 2); tick(); req(1, 3, 0); tick(); req(1, 3, 1); tick();
    idle(1);

    // R6: legal writes on both selectors and reads of each CPU
    phase = "R6";
    wr(1, 1, 32'h1234_5678); tick();
    wr(2, 0, 32'hCAFE_F00D); tick();
    for (int c = 0; c < 4; c++) begin regCpu = 2'(c); regWrSel = ~regWrSel; tick(); end

    // R7: wrong-parity writes ignored and flagged
    phase = "R7";
    wr(1, 0, 32'h0); tick();
    wr(2, 1, 32'h0); tick();
    regCpu = 2'd1; tick(); regCpu = 2'd2; tick();
    wr(0, 0, 32'hFFFF_FFFF); tick(); idle(2);

    // R8: re-post of still-pending classes on enabling write
    phase = "R8";
    wr(1, 1, 32'h0); tick();
    consPend[1] = 1; clkPend[1] = 1; ipiPend[1] = 1; netPend[1] = 1; diskPend[1] = 1;
    idle(1);
    wr(1, 1, 32'h0000_0044); tick(); idle(3);
    wr(1, 1, 32'h0000_0025); tick(); idle(5);
    consPend = '0; clkPend = '0; ipiPend = '0; netPend = '0; diskPend = '0;

    // R9: burst across CPUs, one post per cycle in priority order
    phase = "R9";
    consPend = 4'b1010; ipiPend = 4'b1111; diskPend = 4'b0110;
    wr(3, 1, 32'hFFFF_FFFF); tick();
    wr(2, 0, 32'hFFFF_FFFF); tick();
    wr(1, 1, 32'hFFFF_FFFF); tick();
    req(0, 2, 0); tick();
    idle(10);
    consPend = '0; ipiPend = '0; diskPend = '0;

    // R10: request coinciding with a write, held posts and merges
    phase = "R10";
    consPend[0] = 1;
    wr(0, 0, 32'h0000_0041); req(0, 2, 0); tick(); idle(3);
    wr(2, 0, 32'h0); req(2, 0, 0); tick(); idle(2);
    wr(2, 0, 32'h1); req(2, 0, 0); tick(); idle(2);
    consPend[0] = 0;
    diskPend = 4'b1111;
    wr(0, 0, 32'hFFFF_FFFF); tick();
    req(3, 0, 0); tick();
    req(3, 0, 0); wr(3, 1, 32'h0); tick();
    req(3, 1, 5); tick(); req(3, 1, 6); tick();
    idle(4);
    diskPend = '0;
    wr(3, 1, 32'hFFFF_FFFF); tick();
    wr(0, 0, 32'h0000_0004); tick();
    req(0, 1, 8); tick(); req(0, 1, 12); tick(); idle(3);

    // R9: random traffic against the model
    phase = "R9 random";
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 8) == 0) begin
        consPend = 4'($urandom); clkPend = 4'($urandom); ipiPend = 4'($urandom);
        netPend = 4'($urandom); diskPend = 4'($urandom);
      end
      if (($urandom % 2) == 0)
        req(int'($urandom % 4), int'($urandom % 4), int'($urandom % 16));
      if (($urandom % 6) == 0)
        wr(int'($urandom % 4), int'($urandom % 2), $urandom);
      else
        regCpu = 2'($urandom);
      tick();
    end

    finishRun();
  end

endmodule